// File: doc/BRIEF.md
# Ordered Store Buffer with Load Forwarding

This block sits between one core's load/store interface and a single shared memory port. Stores the core issues are accepted into a small circular queue and written out to memory one at a time, oldest first. The core therefore observes its own writes in program order while other agents see them in issue order, which gives total-store-order behaviour. The core does not wait for its stores to reach memory.

Loads are not held behind buffered stores. A load whose address matches a held store gets its data straight from the queue, from the most recently issued matching entry. A load with no match reads memory through the same port, and it waits only for a write offer that memory has not yet taken. Fence and atomic operations raise a synchronisation request. The block stalls the core on that request until every buffered store has been written to memory.

Top module: `tso_wbuf`

## Requirements
- R1: Buffered stores are written to memory one entry at a time, strictly in the order they were accepted, and each is written exactly once.
- R2: A write offer (`mem_req`=1, `mem_we`=1) that memory does not accept is offered again in the next cycle with the same address and data.
- R3: `st_ready` is 0 exactly when DEPTH (default 8) stores are held. An accepted store with no write completing in the same cycle raises the held count by one.
- R4: A load whose address matches a held store completes with `ld_resp_valid`=1 in the cycle after acceptance. Its data comes from the most recently accepted matching store, and no memory read is made.
- R5: A load that hits in the buffer completes even while older buffered stores are still waiting for memory.
- R6: A load with no match issues a read (`mem_req`=1, `mem_we`=0, `mem_addr`=load address). The read is not offered while a refused write offer is pending. The response carries `mem_rdata` and appears in the cycle after `mem_rvalid`.
- R7: A store and a load accepted in the same cycle to the same address: the load does not see that store's data.
- R8: `drained` is 1 exactly when the buffer is empty. `sync_stall` is 1 while `sync_req` is 1 and the buffer is not empty, and drops in the cycle the last entry drains.
- R9: After reset the buffer is empty, `drained`=1, `st_ready`=1, `ld_ready`=1, `mem_req`=0 and `ld_resp_valid`=0.
- R10: `ld_ready` is 0 from the cycle after a missing load is accepted until its response is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core offers a store |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core offers a load |
| ld_ready | output | 1 | Load can be accepted |
| ld_addr | input | AW | Load address |
| ld_resp_valid | output | 1 | Load result valid (one-cycle pulse) |
| ld_resp_data | output | DW | Load result data |
| sync_req | input | 1 | Fence or atomic operation pending in the core |
| sync_stall | output | 1 | Core must hold until the buffer is empty |
| drained | output | 1 | No buffered stores remain |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |

## Verification
The hardest situation to reach is a load arriving while the buffer is full. In that case memory is refusing a write, several entries share the load address, and a second load that misses must wait behind the refused write. The bench reaches it by holding the modelled memory's ready low while it fills the queue with a chosen address pattern. It then probes forwarding, the stall and the read ordering before it lets memory run. Long sweeps with a pseudo-random ready pattern then mix stores and loads, and the bench checks every memory write against its own record of issue order and every load against a program-order image of memory.

// File: rtl/tso_wb_pkg.sv
package tso_wb_pkg;
    typedef enum logic [1:0] {
        LD_IDLE = 2'd0,
        LD_REQ  = 2'd1,
        LD_WAIT = 2'd2
    } ld_state_e;
endpackage

// File: rtl/tso_wb_queue.sv
// Circular store queue: entries are allocated at the tail and retired at the head.
module tso_wb_queue #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic                       full,
    output logic                       empty,
    output logic [AW-1:0]              head_addr,
    output logic [DW-1:0]              head_data,
    output logic [AW-1:0]              ent_addr [DEPTH],
    output logic [DW-1:0]              ent_data [DEPTH],
    output logic [DEPTH-1:0]           ent_vld,
    output logic [(DEPTH>1 ? $clog2(DEPTH) : 1)-1:0] head_ptr,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct {
        logic [AW-1:0]    addr [DEPTH];
        logic [DW-1:0]    data [DEPTH];
        logic [DEPTH-1:0] vld;
        logic [PW-1:0]    head;
        logic [PW-1:0]    tail;
        logic [CW-1:0]    cnt;
    } q_t;

    q_t s_d, s_q;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.addr[s_q.tail] = push_addr;
            s_d.data[s_q.tail] = push_data;
            s_d.vld[s_q.tail]  = 1'b1;
            s_d.tail           = ptr_inc(s_q.tail);
        end
        if (pop) begin
            s_d.vld[s_q.head] = 1'b0;
            s_d.head          = ptr_inc(s_q.head);
        end
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.vld  <= '0;
            s_q.head <= '0;
            s_q.tail <= '0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign full      = (int'(s_q.cnt) == DEPTH);
    assign empty     = (s_q.cnt == '0);
    assign head_addr = s_q.addr[s_q.head];
    assign head_data = s_q.data[s_q.head];
    assign ent_addr  = s_q.addr;
    assign ent_data  = s_q.data;
    assign ent_vld   = s_q.vld;
    assign head_ptr  = s_q.head;
    assign count     = s_q.cnt;
endmodule

// File: rtl/tso_wb_fwd.sv
// Youngest-match search: walk entries from oldest to youngest, the last hit wins.
module tso_wb_fwd #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic [AW-1:0]    ent_addr [DEPTH],
    input  logic [DW-1:0]    ent_data [DEPTH],
    input  logic [DEPTH-1:0] ent_vld,
    input  logic [(DEPTH>1 ? $clog2(DEPTH) : 1)-1:0] head_ptr,
    input  logic [AW-1:0]    ld_addr,
    output logic             hit,
    output logic [DW-1:0]    hit_data
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [PW-1:0] idx;
            idx = PW'((int'(head_ptr) + k) % DEPTH);
            if (ent_vld[idx] && (ent_addr[idx] == ld_addr)) begin
                hit      = 1'b1;
                hit_data = ent_data[idx];
            end
        end
    end
endmodule

// File: rtl/tso_wb_port.sv
// Memory port arbiter and load sequencer.
module tso_wb_port #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_pend,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          wr_done,
    input  logic          ld_valid,
    input  logic [AW-1:0] ld_addr,
    input  logic          ld_hit,
    input  logic [DW-1:0] ld_fwd_data,
    output logic          ld_ready,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    import tso_wb_pkg::*;

    typedef struct packed {
        ld_state_e     st;
        logic [AW-1:0] rd_addr;
        logic          hold;
        logic          rsp_v;
        logic [DW-1:0] rsp_d;
    } p_t;

    p_t   s_d, s_q;
    logic rd_sel;

    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = 1'b0;

        // A read goes out only when no refused write offer is outstanding.
        rd_sel    = (s_q.st == LD_REQ) && !s_q.hold;
        mem_req   = rd_sel || wr_pend;
        mem_we    = !rd_sel;
        mem_addr  = rd_sel ? s_q.rd_addr : wr_addr;
        mem_wdata = wr_data;
        wr_done   = mem_req && mem_we && mem_ready;
        s_d.hold  = mem_req && mem_we && !mem_ready;
        ld_ready  = (s_q.st == LD_IDLE);

        case (s_q.st)
            LD_IDLE: begin
                if (ld_valid) begin
                    if (ld_hit) begin
                        s_d.rsp_v = 1'b1;
                        s_d.rsp_d = ld_fwd_data;
                    end else begin
                        s_d.st      = LD_REQ;
                        s_d.rd_addr = ld_addr;
                    end
                end
            end
            LD_REQ: begin
                if (rd_sel && mem_ready) s_d.st = LD_WAIT;
            end
            LD_WAIT: begin
                if (mem_rvalid) begin
                    s_d.rsp_v = 1'b1;
                    s_d.rsp_d = mem_rdata;
                    s_d.st    = LD_IDLE;
                end
            end
            default: s_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ld_resp_valid = s_q.rsp_v;
    assign ld_resp_data  = s_q.rsp_d;
endmodule

// File: rtl/tso_wbuf.sv
module tso_wbuf #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data,
    input  logic          sync_req,
    output logic          sync_stall,
    output logic          drained,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ready,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic             q_full, q_empty, wr_done_w, ld_hit_w, ld_acc_w;
    logic [AW-1:0]    head_addr_w;
    logic [DW-1:0]    head_data_w, fwd_data_w;
    logic [AW-1:0]    ent_addr_w [DEPTH];
    logic [DW-1:0]    ent_data_w [DEPTH];
    logic [DEPTH-1:0] ent_vld_w;
    logic [PW-1:0]    head_ptr_w;
    logic [CW-1:0]    count_w;

    assign st_ready   = !q_full;
    assign drained    = q_empty;
    assign sync_stall = sync_req && !q_empty;
    assign ld_acc_w   = ld_valid;

    tso_wb_queue #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (st_valid && !q_full),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (wr_done_w),
        .full      (q_full),
        .empty     (q_empty),
        .head_addr (head_addr_w),
        .head_data (head_data_w),
        .ent_addr  (ent_addr_w),
        .ent_data  (ent_data_w),
        .ent_vld   (ent_vld_w),
        .head_ptr  (head_ptr_w),
        .count     (count_w)
    );

    tso_wb_fwd #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fwd (
        .ent_addr (ent_addr_w),
        .ent_data (ent_data_w),
        .ent_vld  (ent_vld_w),
        .head_ptr (head_ptr_w),
        .ld_addr  (ld_addr),
        .hit      (ld_hit_w),
        .hit_data (fwd_data_w)
    );

    tso_wb_port #(.AW(AW), .DW(DW)) u_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_pend       (!q_empty),
        .wr_addr       (head_addr_w),
        .wr_data       (head_data_w),
        .wr_done       (wr_done_w),
        .ld_valid      (ld_acc_w),
        .ld_addr       (ld_addr),
        .ld_hit        (ld_hit_w),
        .ld_fwd_data   (fwd_data_w),
        .ld_ready      (ld_ready),
        .ld_resp_valid (ld_resp_valid),
        .ld_resp_data  (ld_resp_data),
        .mem_req       (mem_req),
        .mem_we        (mem_we),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata),
        .mem_ready     (mem_ready),
        .mem_rvalid    (mem_rvalid),
        .mem_rdata     (mem_rdata)
    );
endmodule

// File: rtl/tso_wbuf_chk.sv
module tso_wbuf_chk #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic          ld_resp_valid,
    input logic          ld_hit,
    input logic          sync_stall,
    input logic          drained,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic [DW-1:0] mem_wdata,
    input logic [CW-1:0] count,
    input logic          wr_done
);
    // R2: a refused write offer is repeated unchanged
    p_hold_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |=> (mem_req && mem_we && $stable(mem_addr) && $stable(mem_wdata)));

    // R3: refusal only when the queue is full; an accepted store grows the count
    p_refuse_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> (int'(count) == DEPTH));
    p_count_grow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && !wr_done) |=> (count == $past(count) + 1'b1));

    // R4: a forwarded load answers in the next cycle
    p_hit_resp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && ld_hit) |=> ld_resp_valid);

    // R6: no read leaves while a refused write is pending
    p_read_behind_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ready) |=> !(mem_req && !mem_we));

    // R8: a stalled core always has memory traffic in flight; an empty buffer writes nothing
    p_stall_traffic_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sync_stall |-> mem_req);
    p_drained_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        drained |-> !(mem_req && mem_we));

    // R10: a missing load blocks further loads
    p_miss_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && ld_ready && !ld_hit) |=> !ld_ready);
endmodule

bind tso_wbuf tso_wbuf_chk #(
    .AW(AW), .DW(DW), .DEPTH(DEPTH), .CW($clog2(DEPTH + 1))
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .ld_valid      (ld_valid),
    .ld_ready      (ld_ready),
    .ld_resp_valid (ld_resp_valid),
    .ld_hit        (ld_hit_w),
    .sync_stall    (sync_stall),
    .drained       (drained),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_ready     (mem_ready),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .count         (count_w),
    .wr_done       (wr_done_w)
);

// File: tb/sim_tso_wbuf.sv
`timescale 1ns/1ps
module sim_tso_wbuf;
    localparam int AW = 32, DW = 32, DEPTH = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic st_valid = 0, ld_valid = 0, sync_req = 0;
    logic [AW-1:0] st_addr = '0, ld_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic st_ready, ld_ready, ld_resp_valid, sync_stall, drained;
    logic [DW-1:0] ld_resp_data, mem_wdata;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic mem_ready, mem_rvalid = 0;
    logic [DW-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    tso_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [DW-1:0] mem [16];
    logic [DW-1:0] refm [16];
    logic [AW-1:0] exp_a [1024];
    logic [DW-1:0] exp_d [1024];
    int wi = 0, ri = 0;
    int rdy_mode = 1;
    logic [7:0] lfsr = 8'hA5;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // ready pattern
    always @(negedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    assign mem_ready = (rdy_mode == 2) ? (lfsr[0] | lfsr[3]) : (rdy_mode == 1);

    // memory model, write-order check (R1)
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req && mem_ready) begin
            if (mem_we) begin
                chk(ri < wi && exp_a[ri] == mem_addr && exp_d[ri] == mem_wdata,
                    "R1 write order", mem_wdata, (ri < wi) ? exp_d[ri] : 32'hx);
                mem[mem_addr[3:0]] = mem_wdata;
                ri++;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr[3:0]];
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        st_addr = a; st_data = d; st_valid = 1;
        for (int n = 0; n < 500 && !st_ready; n++) @(negedge clk);
        refm[a[3:0]] = d;
        exp_a[wi] = a; exp_d[wi] = d; wi++;
        @(negedge clk);
        st_valid = 0;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input string req);
        logic [DW-1:0] e;
        for (int n = 0; n < 500 && !ld_ready; n++) @(negedge clk);
        e = refm[a[3:0]];
        ld_addr = a; ld_valid = 1;
        @(negedge clk);
        ld_valid = 0;
        for (int n = 0; n < 500 && !ld_resp_valid; n++) @(negedge clk);
        chk(ld_resp_valid && ld_resp_data == e, req, ld_resp_data, e);
        @(negedge clk);
    endtask

    task automatic wait_drained();
        for (int n = 0; n < 2000 && !drained; n++) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        chk(0, "watchdog", 0, 0);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]  = 32'h1111_0000 * i + i;
            refm[i] = 32'h1111_0000 * i + i;
        end
        repeat (3) @(negedge clk);
        chk(drained && st_ready && ld_ready && !mem_req && !ld_resp_valid, "R9 reset",
            {drained, st_ready, ld_ready, mem_req, ld_resp_valid}, 5'b11100);
        rst_n = 1;
        @(negedge clk);
        chk(drained && st_ready && ld_ready && !mem_req && !ld_resp_valid, "R9 after reset",
            {drained, st_ready, ld_ready, mem_req, ld_resp_valid}, 5'b11100);

        // directed: memory stalled, fill queue
        rdy_mode = 0;
        do_store(32'd5, 32'hAAAA_0005);
        do_load(32'd5, "R5 bypass hit while write pending");
        chk(mem_req && mem_we && mem_addr == 32'd5, "R5 write still pending", mem_addr, 32'd5);
        chk(!drained, "R8 drained low when holding", drained, 0);
        do_store(32'd9, 32'h0000_0901);
        do_store(32'd3, 32'h0000_0301);
        do_store(32'd9, 32'h0000_0902);
        do_store(32'd7, 32'h0000_0701);
        do_store(32'd9, 32'h0000_0903);
        do_store(32'd2, 32'h0000_0201);
        chk(st_ready, "R3 ready with 7 held", st_ready, 1);
        do_store(32'd4, 32'h0000_0401);
        chk(!st_ready, "R3 refused with 8 held", st_ready, 0);
        do_load(32'd9, "R4 youngest of three matches");
        chk(refm[9] == 32'h0000_0903, "R4 reference youngest", refm[9], 32'h0000_0903);
        sync_req = 1;
        @(negedge clk);
        chk(sync_stall, "R8 stall while nonempty", sync_stall, 1);

        // missing load waits behind the refused write
        ld_addr = 32'd12; ld_valid = 1;
        @(negedge clk);
        ld_valid = 0;
        chk(!ld_ready, "R10 ld_ready low during miss", ld_ready, 0);
        chk(mem_req && mem_we, "R6 read held behind write", mem_we, 1);
        rdy_mode = 1;
        for (int n = 0; n < 200 && !ld_resp_valid; n++) begin
            @(negedge clk);
            if (!drained) chk(sync_stall, "R8 stall holds until empty", sync_stall, 1);
        end
        chk(ld_resp_valid && ld_resp_data == refm[12], "R6 miss data", ld_resp_data, refm[12]);
        wait_drained();
        chk(drained && !sync_stall, "R8 stall released on empty", sync_stall, 0);
        sync_req = 0;
        @(negedge clk);

        // R7 same-cycle store and load to one address
        for (int k = 0; k < 2; k++) begin
            logic [DW-1:0] e;
            e = refm[6];
            st_addr = 32'd6; st_data = 32'h6600_0000 + k; st_valid = 1;
            ld_addr = 32'd6; ld_valid = 1;
            refm[6] = st_data; exp_a[wi] = 32'd6; exp_d[wi] = st_data; wi++;
            @(negedge clk);
            st_valid = 0; ld_valid = 0;
            for (int n = 0; n < 200 && !ld_resp_valid; n++) @(negedge clk);
            chk(ld_resp_valid && ld_resp_data == e, "R7 same-cycle load sees old", ld_resp_data, e);
            @(negedge clk);
            do_load(32'd6, "R4 later load sees the store");
            wait_drained();
        end

        // sweeps
        for (int m = 1; m <= 2; m++) begin
            rdy_mode = m;
            for (int i = 0; i < 240; i++) begin
                case (i % 4)
                    0, 1: do_store(AW'((i * 7) % 16), 32'h0101_0101 * i ^ m);
                    2:    do_load(AW'((i * 3) % 16), "R4/R6 sweep load");
                    default: do_load(AW'(((i - 2) * 7) % 16), "R4/R6 sweep recent");
                endcase
            end
            wait_drained();
            repeat (2) @(negedge clk);
            for (int a = 0; a < 16; a++)
                chk(mem[a] == refm[a], "R1 final memory image", mem[a], refm[a]);
        end
        chk(ri == wi, "R1 every store written once", ri, wi);
        finish_run();
    end
endmodule